// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit keeps a small file of data pointers and, on each requested cycle, produces one data-memory address while writing back the selected pointer. A request names the pointer, an operation mode, a signed step and which of two buffer sizes applies. The unit returns the effective address and the pointer's new value one clock later.

Plain pointer arithmetic can modify the pointer before the access, with the new value used as the address, or after it, with the old value used. Two further operations serve signal-processing loops. Circular stepping wraps a pointer inside a power-of-two buffer that is aligned to its own size. Bit-reversed stepping adds the step with the carry running from the top of the field towards bit 0, so a pointer advanced by half the buffer size visits indices in FFT butterfly order.

Top module: `dsp_agu`

## Requirements
- R1: After reset every pointer is 0, `addr` and `ptr_new` are 0, and `addr_valid` is 0.
- R2: Mode 6 (load) writes `load_val` into the selected pointer. `addr` and `ptr_new` both show `load_val`.
- R3: Modes 0 and 7 (plain indirect) return the selected pointer on both `addr` and `ptr_new` and leave it unchanged.
- R4: Mode 1 (pre-modify) sets the pointer to pointer + sign-extended step, modulo 2^ADDR_W. `addr` equals that new value.
- R5: Mode 2 (post-modify) writes pointer + sign-extended step back. `addr` is the old value and `ptr_new` is the new value.
- R6: Modes 3 (circular pre) and 4 (circular post) change only the low L bits of the pointer, to (low bits + step) mod 2^L, and keep the upper bits. L is LOG_SIZE_A when `size_sel`=0 and LOG_SIZE_B when `size_sel`=1. This holds for negative steps and for steps above one. Mode 3 puts the new value on `addr`; mode 4 puts the old value there.
- R7: Mode 5 (bit-reversed post) replaces the low L bits with the bit mirror of (mirror(low bits) + mirror(low L bits of step)) mod 2^L and keeps the upper bits. `addr` is the old value. With L=3 and step 4, the sequence from 0 is 0,4,2,6,1,5,3,7,0.
- R8: `addr`, `ptr_new` and `addr_valid` are registered. They reflect a request one clock after it. `addr_valid` is 1 exactly in the cycle after `req`. Without `req`, no pointer changes and `addr` and `ptr_new` hold.
- R9: A request changes only the selected pointer; all other pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request an address this cycle |
| ptr_sel | input | PSEL_W | Pointer index |
| mode | input | 3 | Operation (0/7 indirect, 1 pre, 2 post, 3 circ pre, 4 circ post, 5 bit-reversed, 6 load) |
| step | input | STEP_W | Signed modify step |
| size_sel | input | 1 | Buffer size choice: 0 selects 2^LOG_SIZE_A, 1 selects 2^LOG_SIZE_B |
| load_val | input | ADDR_W | Value for load mode |
| addr | output | ADDR_W | Effective address |
| ptr_new | output | ADDR_W | Pointer value after the update |
| addr_valid | output | 1 | Address valid, one cycle after `req` |

## Verification
A corrupted pointer does not show up at once. It appears on the next request that names that pointer, in the cycle after the request. A post-modify or indirect access shows it directly on `addr`. A wrong carry direction or wrong field mask in circular or bit-reversed mode shows as altered upper bits, or a broken visiting order, within one buffer length of steps. A stray write to an unselected pointer is only visible when that pointer is next read. For this reason, random traffic re-reads every pointer often and compares each result against a reference model of all the pointers.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [2:0] {
        AGU_HOLD  = 3'd0,
        AGU_PRE   = 3'd1,
        AGU_POST  = 3'd2,
        AGU_CPRE  = 3'd3,
        AGU_CPOST = 3'd4,
        AGU_BREV  = 3'd5,
        AGU_LOAD  = 3'd6,
        AGU_RSVD  = 3'd7
    } agu_mode_e;
endpackage

// File: rtl/agu_circ_step.sv
// Modulo step inside a size-aligned power-of-two window.
module agu_circ_step #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  inc,
    input  logic [LW-1:0] lsz,
    output logic [W-1:0]  result
);
    logic [W-1:0] mask;
    logic [W-1:0] sum;

    always_comb begin
        mask   = ~({W{1'b1}} << lsz);
        sum    = base + inc;
        result = (base & ~mask) | (sum & mask);
    end
endmodule

// File: rtl/agu_brev_step.sv
// Reverse-carry adder: the carry ripples from bit lsz-1 down to bit 0.
module agu_brev_step #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  inc,
    input  logic [LW-1:0] lsz,
    output logic [W-1:0]  result
);
    logic carry;

    always_comb begin
        carry  = 1'b0;
        result = base;
        for (int i = W - 1; i >= 0; i--) begin
            if (i < int'(lsz)) begin
                result[i] = base[i] ^ inc[i] ^ carry;
                carry     = (base[i] & inc[i]) | (carry & (base[i] ^ inc[i]));
            end
        end
    end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
    parameter int ADDR_W     = 16,
    parameter int STEP_W     = 12,
    parameter int NUM_PTR    = 8,
    parameter int LOG_SIZE_A = 3,
    parameter int LOG_SIZE_B = 6,
    localparam int PSEL_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
    localparam int LSZ_W     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [PSEL_W-1:0] ptr_sel,
    input  logic [2:0]        mode,
    input  logic [STEP_W-1:0] step,
    input  logic              size_sel,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] ptr_new,
    output logic              addr_valid
);
    import agu_pkg::*;

    typedef struct packed {
        logic [NUM_PTR-1:0][ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0]              addr;
        logic [ADDR_W-1:0]              ptr_new;
        logic                           valid;
    } agu_state_t;

    agu_state_t        st_d, st_q;
    agu_mode_e         op;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] step_ext;
    logic [ADDR_W-1:0] lin_nxt;
    logic [ADDR_W-1:0] circ_nxt;
    logic [ADDR_W-1:0] brev_nxt;
    logic [LSZ_W-1:0]  lsz;

    assign op       = agu_mode_e'(mode);
    assign cur      = st_q.ptr[ptr_sel];
    assign step_ext = ADDR_W'($signed(step));
    assign lsz      = size_sel ? LSZ_W'(LOG_SIZE_B) : LSZ_W'(LOG_SIZE_A);
    assign lin_nxt  = cur + step_ext;

    agu_circ_step #(.W(ADDR_W), .LW(LSZ_W)) u_circ (
        .base(cur), .inc(step_ext), .lsz(lsz), .result(circ_nxt)
    );

    agu_brev_step #(.W(ADDR_W), .LW(LSZ_W)) u_brev (
        .base(cur), .inc(step_ext), .lsz(lsz), .result(brev_nxt)
    );

    always_comb begin
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] ea;
        st_d       = st_q;
        st_d.valid = req;
        nxt        = cur;
        ea         = cur;
        unique case (op)
            AGU_PRE:   begin nxt = lin_nxt;  ea = lin_nxt;  end
            AGU_POST:  begin nxt = lin_nxt;  ea = cur;      end
            AGU_CPRE:  begin nxt = circ_nxt; ea = circ_nxt; end
            AGU_CPOST: begin nxt = circ_nxt; ea = cur;      end
            AGU_BREV:  begin nxt = brev_nxt; ea = cur;      end
            AGU_LOAD:  begin nxt = load_val; ea = load_val; end
            default:   begin nxt = cur;      ea = cur;      end
        endcase
        if (req) begin
            for (int p = 0; p < NUM_PTR; p++) begin
                if (PSEL_W'(p) == ptr_sel) st_d.ptr[p] = nxt;
            end
            st_d.addr    = ea;
            st_d.ptr_new = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr       = st_q.addr;
    assign ptr_new    = st_q.ptr_new;
    assign addr_valid = st_q.valid;
endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
    parameter int ADDR_W     = 16,
    parameter int STEP_W     = 12,
    parameter int PSEL_W     = 3,
    parameter int LOG_SIZE_A = 3,
    parameter int LOG_SIZE_B = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [PSEL_W-1:0] ptr_sel,
    input logic [2:0]        mode,
    input logic [STEP_W-1:0] step,
    input logic              size_sel,
    input logic [ADDR_W-1:0] load_val,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] ptr_new,
    input logic              addr_valid
);
    logic [ADDR_W-1:0] sx;
    logic [ADDR_W-1:0] msk;
    logic              unused_ok;

    assign sx        = ADDR_W'($signed(step));
    assign msk       = size_sel ? ~({ADDR_W{1'b1}} << LOG_SIZE_B) : ~({ADDR_W{1'b1}} << LOG_SIZE_A);
    assign unused_ok = ^ptr_sel;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_valid && $stable(addr) && $stable(ptr_new));
    assert_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_valid);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd6 |=> addr == $past(load_val) && ptr_new == $past(load_val));
    assert_ind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req && (mode == 3'd0 || mode == 3'd7) |=> addr == ptr_new);
    assert_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd1 |=> addr == ptr_new);
    assert_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd2 |=> ptr_new == addr + $past(sx));
    assert_circ_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd4 |=> ((addr ^ ptr_new) & ~$past(msk)) == '0);
    assert_circ_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd4 |=> ((ptr_new - addr - $past(sx)) & $past(msk)) == '0);
    assert_brev_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == 3'd5 |=> ((addr ^ ptr_new) & ~$past(msk)) == '0);
endmodule

bind dsp_agu dsp_agu_chk #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .PSEL_W(PSEL_W),
    .LOG_SIZE_A(LOG_SIZE_A), .LOG_SIZE_B(LOG_SIZE_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .ptr_sel(ptr_sel), .mode(mode),
    .step(step), .size_sel(size_sel), .load_val(load_val), .addr(addr),
    .ptr_new(ptr_new), .addr_valid(addr_valid)
);

// File: tb/test_dsp_agu.sv
`timescale 1ns/1ps
module test_dsp_agu;
    localparam int AW = 16;
    localparam int SW = 12;
    localparam int NP = 8;
    localparam int LA = 3;
    localparam int LB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    ptr_sel = '0;
    logic [2:0]    mode = '0;
    logic [SW-1:0] step = '0;
    logic          size_sel = 1'b0;
    logic [AW-1:0] load_val = '0;
    logic [AW-1:0] addr, ptr_new;
    logic          addr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [AW-1:0] model [NP];

    always #2 clk = ~clk;

    dsp_agu #(.ADDR_W(AW), .STEP_W(SW), .NUM_PTR(NP), .LOG_SIZE_A(LA), .LOG_SIZE_B(LB)) i_dsp_agu (
        .clk(clk), .rst_n(rst_n), .req(req), .ptr_sel(ptr_sel), .mode(mode),
        .step(step), .size_sel(size_sel), .load_val(load_val),
        .addr(addr), .ptr_new(ptr_new), .addr_valid(addr_valid)
    );

    task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] x, input int l);
        logic [AW-1:0] r = '0;
        for (int i = 0; i < l; i++) r[l-1-i] = x[i];
        return r;
    endfunction

    // Reference result of one request, from the requirement text.
    function automatic void expect_op(input logic [AW-1:0] old, input logic [2:0] m,
                                      input logic [SW-1:0] s, input logic ss,
                                      input logic [AW-1:0] ld,
                                      output logic [AW-1:0] ea, output logic [AW-1:0] np);
        int l = ss ? LB : LA;
        logic [AW-1:0] se  = {{(AW-SW){s[SW-1]}}, s};
        logic [AW-1:0] lo  = (AW'(1) << l) - 1;
        logic [AW-1:0] hi  = ~lo;
        logic [AW-1:0] rsum;
        case (m)
            3'd1: begin np = old + se; ea = np; end
            3'd2: begin np = old + se; ea = old; end
            3'd3: begin np = (old & hi) | ((old + se) & lo); ea = np; end
            3'd4: begin np = (old & hi) | ((old + se) & lo); ea = old; end
            3'd5: begin
                rsum = (mirror(old & lo, l) + mirror(se & lo, l)) & lo;
                np = (old & hi) | mirror(rsum, l); ea = old;
            end
            3'd6: begin np = ld; ea = ld; end
            default: begin np = old; ea = old; end
        endcase
    endfunction

    // Drive at a falling edge, check at the next falling edge.
    task automatic op(input string tag, input int sel, input logic [2:0] m,
                      input int s, input logic ss, input logic [AW-1:0] ld);
        logic [AW-1:0] ea, np;
        expect_op(model[sel], m, SW'(s), ss, ld, ea, np);
        req = 1'b1; ptr_sel = 3'(sel); mode = m; step = SW'(s); size_sel = ss; load_val = ld;
        @(negedge clk);
        req = 1'b0;
        model[sel] = np;
        chk({tag, " addr"}, addr, ea);
        chk({tag, " ptr_new"}, ptr_new, np);
        chk({tag, " valid"}, AW'(addr_valid), AW'(1));
    endtask

    task automatic idle_check();
        logic [AW-1:0] a0 = addr, p0 = ptr_new;
        req = 1'b0; mode = 3'd6; load_val = 16'hDEAD;
        @(negedge clk);
        chk("R8 idle valid", AW'(addr_valid), AW'(0));
        chk("R8 idle addr", addr, a0);
        chk("R8 idle ptr_new", ptr_new, p0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1d5a_0c37;
        int rv;
        for (int i = 0; i < NP; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr", addr, '0);
        chk("R1 ptr_new", ptr_new, '0);
        chk("R1 valid", AW'(addr_valid), '0);
        op("R1 ptr5 indirect", 5, 3'd0, 0, 1'b0, '0);

        // R2 load, R3 indirect (mode 7 too)
        op("R2 load ptr0", 0, 3'd6, 0, 1'b0, 16'h1238);
        op("R3 indirect ptr0", 0, 3'd0, 9, 1'b0, '0);
        op("R3 mode7 ptr0", 0, 3'd7, 9, 1'b0, '0);
        // R6 circular post, size 8, step 3 wraps 6->1; negative step
        op("R6 cpost a", 0, 3'd4, 3, 1'b0, '0);
        op("R6 cpost b", 0, 3'd4, 3, 1'b0, '0);
        op("R6 cpost wrap", 0, 3'd4, 3, 1'b0, '0);
        op("R6 cpost read", 0, 3'd0, 0, 1'b0, '0);
        chk("R6 wrapped value", ptr_new, 16'h1239);
        op("R6 cpre neg", 0, 3'd3, -5, 1'b0, '0);
        chk("R6 neg wrap", addr, 16'h123C);
        op("R6 big size", 0, 3'd3, 70, 1'b1, '0);
        // R4 pre below zero, R5 post
        op("R2 load ptr2", 2, 3'd6, 0, 1'b0, 16'h0000);
        op("R4 pre neg", 2, 3'd1, -1, 1'b0, '0);
        chk("R4 wrap to top", addr, 16'hFFFF);
        op("R5 post", 2, 3'd2, 2047, 1'b0, '0);
        chk("R5 old addr", addr, 16'hFFFF);
        // R7 butterfly order 0,4,2,6,1,5,3,7,0
        op("R2 load ptr1", 1, 3'd6, 0, 1'b0, 16'h0400);
        begin
            logic [2:0] order [9] = '{3'd0, 3'd4, 3'd2, 3'd6, 3'd1, 3'd5, 3'd3, 3'd7, 3'd0};
            for (int k = 0; k < 9; k++) begin
                op("R7 brev step", 1, 3'd5, 4, 1'b0, '0);
                chk("R7 butterfly order", addr, 16'h0400 | AW'(order[k]));
            end
        end
        // R8 idle
        idle_check();
        // R9 other pointers untouched
        op("R9 ptr5 still zero", 5, 3'd0, 0, 1'b0, '0);
        chk("R9 ptr5 value", addr, 16'h0000);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            rv = int'($urandom(seed) % 16);
            seed = seed + 1;
            if (rv == 0) idle_check();
            else begin
                int sel = int'($urandom() % NP);
                logic [2:0] m = 3'($urandom() % 8);
                int s = int'($urandom() % 64) - 32;
                logic ss = 1'($urandom() % 2);
                logic [AW-1:0] ld = AW'($urandom());
                if (m == 3'd5 && ($urandom() % 2) == 1) s = ss ? 32 : 4;
                op("R9 random", sel, m, s, ss, ld);
            end
        end
        for (int i = 0; i < NP; i++) op("R9 final readback", i, 3'd0, 0, 1'b0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule